// File: doc/BRIEF.md
# Fetch/Decode Hazard Stall Interlock

This block joins an in-order fetch stage to a decode stage and manages what happens when decode finds that the instruction in front of it cannot proceed because an operand is not ready. Decode parks that instruction in a private holding register and raises a registered stall toward fetch. Fetch then keeps its program counter where it is and keeps sending the same younger instruction every cycle. Decode ignores those copies, works from its holding register, and sends bubbles to execute until the hazard input drops. It then releases the parked instruction to execute and lowers stall. On the following cycle fetch steps forward again and decode picks up the younger instruction from the channel.

The hazard input comes from an external register scoreboard. That scoreboard inspects the instruction that decode is presenting on `dec_pc`. A flush input with a redirect address discards everything in the interlock, clears the holding register and restarts fetch at the new address.

Top module: `fetch_decode_interlock`

## Requirements
- R1: When `hazard` is high in a cycle where `dec_valid` is high and `flush` is low, `fetch_stall` is high in the next cycle. It stays high for exactly as many cycles as `hazard` is held against that instruction.
- R2: During every cycle with `fetch_stall` high, `imem_addr` equals the parked instruction's address plus 4. Fetch neither advances past that younger instruction nor drops it.
- R3: Execute receives instructions in strict program order, each address 4 above the previous, with none lost or repeated. `ex_instr` is the word that memory returned for `ex_pc`.
- R4: While `fetch_stall` is high, `dec_valid` is high and `dec_pc` shows the parked instruction, not the channel contents.
- R5: `ex_valid` is low in every cycle in which `fetch_stall` is high.
- R6: In the cycle after the hazard clears, `ex_valid` is high with the parked instruction and `fetch_stall` is low. The younger instruction reaches execute one cycle later.
- R7: Copies of the younger instruction that arrive while the stall is in force do not overwrite the parked instruction. The word released is the parked one.
- R8: A `flush` pulse gives `ex_valid` low and `fetch_stall` low in the next cycle, even in the middle of a stall. It also gives a second bubble one cycle after that. The instruction at `flush_pc` reaches execute three cycles after the flush cycle, followed by its successors.
- R9: `hazard` has no effect in a cycle where `dec_valid` is low.
- R10: Right after reset: `ex_valid`, `dec_valid` and `fetch_stall` are low, and `imem_addr` equals `RESET_PC`.
- R11: With no hazard, the instruction at `RESET_PC` is in execute two cycles after reset is released, and one new instruction arrives per cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | ADDR_W | Address fetched this cycle |
| imem_data | input | INSTR_W | Instruction word at `imem_addr`, same cycle |
| hazard | input | 1 | Scoreboard says the instruction on `dec_pc` must wait |
| flush | input | 1 | Discard in-flight work and redirect fetch |
| flush_pc | input | ADDR_W | Restart address used with `flush` |
| fetch_stall | output | 1 | Registered stall seen by fetch |
| dec_valid | output | 1 | Decode holds an instruction this cycle |
| dec_pc | output | ADDR_W | Address of the instruction under decode |
| ex_valid | output | 1 | Decode-to-execute slot holds an instruction |
| ex_pc | output | ADDR_W | Address sent to execute |
| ex_instr | output | INSTR_W | Instruction word sent to execute |

## Verification
A holding register that is loaded during a stall makes itself visible in the release cycle. A younger word appears on `ex_instr`, and that same address appears again one cycle later. A stall register that stays high too long or drops too early shifts every later address on `ex_pc` by a cycle. The sequence check catches this at the first instruction after the hazard. A program counter that moves while stalled is visible on `imem_addr` during the stall itself. It also leaves a gap in the execute stream two cycles after the release.

// File: rtl/fdi_pkg.sv
// Shared widths and the fetch-to-decode channel record.
// Assumes byte addressing with fixed-size instruction words.
package fdi_pkg;
    localparam int ADDR_W  = 32;
    localparam int INSTR_W = 32;

    typedef struct packed {
        logic               valid;
        logic [ADDR_W-1:0]  pc;
        logic [INSTR_W-1:0] instr;
    } fdi_slot_t;
endpackage

// File: rtl/fdi_fetch.sv
// Fetch stage: holds the address of the instruction last placed on the
// channel. When the registered stall is seen, that same address is fetched
// and sent again; otherwise the next sequential word is fetched.
// Assumes instruction memory answers combinationally in the same cycle.
module fdi_fetch
    import fdi_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_PC = 32'h0000_0100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stall_in,
    input  logic               flush_in,
    input  logic [ADDR_W-1:0]  flush_pc,
    output logic [ADDR_W-1:0]  imem_addr,
    input  logic [INSTR_W-1:0] imem_data,
    output fdi_slot_t          chan
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_W / 8);

    logic [ADDR_W-1:0] sent_pc_q;
    logic [ADDR_W-1:0] next_pc;
    fdi_slot_t         chan_q;

    // Pick the address to fetch: repeat the last one while stalled.
    always_comb begin
        next_pc = stall_in ? sent_pc_q : sent_pc_q + STEP;
    end

    assign imem_addr = next_pc;
    assign chan      = chan_q;

    // Advance the channel register and the sent-address register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sent_pc_q <= RESET_PC - STEP;
            chan_q    <= '0;
        end else if (flush_in) begin
            sent_pc_q <= flush_pc - STEP;
            chan_q    <= '0;
        end else begin
            sent_pc_q <= next_pc;
            chan_q    <= '{valid: 1'b1, pc: next_pc, instr: imem_data};
        end
    end

    logic              chan_valid_w;
    logic [ADDR_W-1:0] chan_pc_w;
    assign chan_valid_w = chan_q.valid;
    assign chan_pc_w    = chan_q.pc;

    AST_RESEND_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_in && !flush_in && chan_valid_w) |=> (chan_valid_w && chan_pc_w == $past(chan_pc_w))); // R2
    AST_SEQUENTIAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_in && !flush_in && chan_valid_w) |=> (chan_valid_w && chan_pc_w == $past(chan_pc_w) + STEP)); // R3
    AST_FLUSH_EMPTIES_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
        flush_in |=> !chan_valid_w); // R8
endmodule

// File: rtl/fdi_decode.sv
// Decode stage interlock: parks the instruction that meets a hazard,
// raises a registered stall, sends bubbles while parked and releases the
// parked instruction once the hazard input drops.
// Assumes the hazard input refers to the instruction shown on dec_pc.
module fdi_decode
    import fdi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  fdi_slot_t         chan,
    input  logic              hazard,
    input  logic              flush_in,
    output logic              stall_out,
    output logic              dec_valid,
    output logic [ADDR_W-1:0] dec_pc,
    output fdi_slot_t         ex_slot
);
    logic               stall_q;
    logic [ADDR_W-1:0]  park_pc_q;
    logic [INSTR_W-1:0] park_instr_q;
    fdi_slot_t          ex_q;
    fdi_slot_t          cur;

    // Select the instruction under decode: parked copy while stalled.
    always_comb begin
        if (stall_q) begin
            cur = '{valid: 1'b1, pc: park_pc_q, instr: park_instr_q};
        end else begin
            cur = chan;
        end
    end

    assign stall_out = stall_q;
    assign dec_valid = cur.valid;
    assign dec_pc    = cur.pc;
    assign ex_slot   = ex_q;

    // Parking register: loads from the channel only when not stalled.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_in) begin
            park_pc_q    <= '0;
            park_instr_q <= '0;
        end else if (!stall_q) begin
            park_pc_q    <= chan.pc;
            park_instr_q <= chan.instr;
        end
    end

    // Stall flag and execute slot: bubble while a hazard holds.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_in) begin
            stall_q <= 1'b0;
            ex_q    <= '0;
        end else if (cur.valid && hazard) begin
            stall_q <= 1'b1;
            ex_q    <= '0;
        end else begin
            stall_q <= 1'b0;
            ex_q    <= cur.valid ? cur : '0;
        end
    end

    logic ex_valid_w;
    logic [ADDR_W-1:0] ex_pc_w;
    assign ex_valid_w = ex_q.valid;
    assign ex_pc_w    = ex_q.pc;

    AST_HAZARD_RAISES_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.valid && hazard && !flush_in) |=> stall_q); // R1
    AST_BUBBLE_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        stall_q |-> !ex_valid_w); // R5
    AST_PARK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_q && !flush_in) |=> $stable(park_pc_q)); // R7
    AST_RELEASE_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_q && !hazard && !flush_in) |=> (ex_valid_w && !stall_q && ex_pc_w == $past(park_pc_q))); // R6
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_in |=> (!ex_valid_w && !stall_q)); // R8
    AST_IDLE_HAZARD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur.valid && !flush_in) |=> !stall_q); // R9
endmodule

// File: rtl/fetch_decode_interlock.sv
// Top level: fetch stage feeding the decode interlock through a one-deep
// channel register; the registered stall returns to fetch.
// Assumes an external scoreboard drives hazard from dec_pc.
module fetch_decode_interlock
    import fdi_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_PC = 32'h0000_0100
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [ADDR_W-1:0]  imem_addr,
    input  logic [INSTR_W-1:0] imem_data,
    input  logic               hazard,
    input  logic               flush,
    input  logic [ADDR_W-1:0]  flush_pc,
    output logic               fetch_stall,
    output logic               dec_valid,
    output logic [ADDR_W-1:0]  dec_pc,
    output logic               ex_valid,
    output logic [ADDR_W-1:0]  ex_pc,
    output logic [INSTR_W-1:0] ex_instr
);
    fdi_slot_t chan;
    fdi_slot_t ex_slot;
    logic      stall_w;

    fdi_fetch #(.RESET_PC(RESET_PC)) fetch_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .stall_in  (stall_w),
        .flush_in  (flush),
        .flush_pc  (flush_pc),
        .imem_addr (imem_addr),
        .imem_data (imem_data),
        .chan      (chan)
    );

    fdi_decode decode_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .chan      (chan),
        .hazard    (hazard),
        .flush_in  (flush),
        .stall_out (stall_w),
        .dec_valid (dec_valid),
        .dec_pc    (dec_pc),
        .ex_slot   (ex_slot)
    );

    assign fetch_stall = stall_w;
    assign ex_valid    = ex_slot.valid;
    assign ex_pc       = ex_slot.pc;
    assign ex_instr    = ex_slot.instr;
endmodule

// File: tb/fetch_decode_interlock_tb.sv
module fetch_decode_interlock_tb_top;
    localparam int          CLK_PERIOD = 10;
    localparam int          NCYC       = 40;
    localparam logic [31:0] RST_PC     = 32'h0000_0100;
    localparam logic [31:0] FL_PC      = 32'h0000_4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_data, flush_pc, dec_pc, ex_pc, ex_instr;
    logic        hazard = 1'b0, flush = 1'b0;
    logic        fetch_stall, dec_valid, ex_valid;

    int tests = 0;
    int fails = 0;

    // expected stream per cycle: 0 bubble, 1 instruction, 2 hazard bubble
    int          exp_kind [NCYC];
    logic [31:0] exp_pc   [NCYC];
    logic [31:0] exp_hpc  [NCYC];

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] word_of(input logic [31:0] a);
        return {a[15:0] ^ 16'hA5C3, a[15:0]};
    endfunction

    assign imem_data = word_of(imem_addr);
    assign flush_pc  = FL_PC;

    fetch_decode_interlock #(.RESET_PC(RST_PC)) dut_i (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
        .hazard(hazard), .flush(flush), .flush_pc(flush_pc),
        .fetch_stall(fetch_stall), .dec_valid(dec_valid), .dec_pc(dec_pc),
        .ex_valid(ex_valid), .ex_pc(ex_pc), .ex_instr(ex_instr)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic build(input int t1, input int l1, input int t2, input int l2, input int kf);
        int c = 2;
        logic [31:0] pc = RST_PC;
        for (int i = 0; i < NCYC; i++) begin
            exp_kind[i] = 0; exp_pc[i] = '0; exp_hpc[i] = '0;
        end
        while (c < NCYC) begin
            int len = 0;
            if (pc == RST_PC + 32'(4*t1)) len = l1;
            if (pc == RST_PC + 32'(4*t2)) len = l2;
            for (int b = 0; b < len; b++) begin
                if (c < NCYC) begin exp_kind[c] = 2; exp_hpc[c] = pc; end
                c++;
            end
            if (c < NCYC) begin exp_kind[c] = 1; exp_pc[c] = pc; end
            c++;
            pc += 4;
        end
        if (kf >= 0) begin
            for (int i = kf + 1; i < NCYC; i++) begin
                if (i <= kf + 2) exp_kind[i] = 0;
                else begin exp_kind[i] = 1; exp_pc[i] = FL_PC + 32'(4*(i-kf-3)); end
            end
        end
    endtask

    task automatic run(input int t1, input int l1, input int t2, input int l2, input int kf);
        int c1 = 0, c2 = 0;
        build(t1, l1, t2, l2, kf);
        @(negedge clk); rst_n = 1'b0; hazard = 1'b0; flush = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        for (int k = 0; k < NCYC; k++) begin
            if (k == 0) begin
                chk(!ex_valid, "R10 ex_valid after reset", 32'(ex_valid), 0);
                chk(!dec_valid, "R10 dec_valid after reset", 32'(dec_valid), 0);
                chk(!fetch_stall, "R10 stall after reset", 32'(fetch_stall), 0);
                chk(imem_addr == RST_PC, "R10 imem_addr after reset", imem_addr, RST_PC);
            end
            if (k == 1 && t1 != 0) chk(!fetch_stall, "R9 idle hazard ignored", 32'(fetch_stall), 0);
            chk(ex_valid == (exp_kind[k] == 1), "R5 R11 ex_valid", 32'(ex_valid), 32'(exp_kind[k] == 1));
            chk(fetch_stall == (exp_kind[k] == 2), "R1 fetch_stall", 32'(fetch_stall), 32'(exp_kind[k] == 2));
            if (exp_kind[k] == 1) begin
                chk(ex_pc == exp_pc[k], "R3 ex_pc order", ex_pc, exp_pc[k]);
                chk(ex_instr == word_of(exp_pc[k]), "R3 ex_instr", ex_instr, word_of(exp_pc[k]));
                if (k > 0 && exp_kind[k-1] == 2) begin
                    chk(ex_pc == exp_hpc[k-1], "R6 released parked pc", ex_pc, exp_hpc[k-1]);
                    chk(ex_instr == word_of(exp_hpc[k-1]), "R7 parked word kept", ex_instr, word_of(exp_hpc[k-1]));
                end
            end
            if (exp_kind[k] == 2) begin
                chk(imem_addr == exp_hpc[k] + 4, "R2 fetch address frozen", imem_addr, exp_hpc[k] + 4);
                chk(dec_valid && dec_pc == exp_hpc[k], "R4 decode shows parked", dec_pc, exp_hpc[k]);
            end
            if (kf >= 0 && (k == kf + 1 || k == kf + 2))
                chk(!ex_valid && !fetch_stall, "R8 flush bubble", {30'd0, ex_valid, fetch_stall}, 0);
            // scoreboard model: hazard on target, and always while decode idle
            hazard = !dec_valid;
            if (dec_valid && dec_pc == RST_PC + 32'(4*t1) && c1 < l1) begin hazard = 1'b1; c1++; end
            else if (dec_valid && dec_pc == RST_PC + 32'(4*t2) && c2 < l2) begin hazard = 1'b1; c2++; end
            flush = (k == kf);
            @(negedge clk);
            #1;
        end
        hazard = 1'b0; flush = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int j = 0; j < 5; j++)
            for (int l = 1; l <= 3; l++)
                run(j, l, 99, 0, -1);
        for (int j = 0; j < 4; j++)
            for (int a = 1; a <= 2; a++)
                for (int b = 1; b <= 2; b++)
                    run(j, a, j + 1, b, -1);
        for (int j = 0; j < 3; j++) run(j, 2, j + 2, 1, -1);
        run(3, 4, 99, 0, 4);
        run(3, 4, 99, 0, 6);
        run(3, 4, 99, 0, 10);
        run(99, 0, 99, 0, 3);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule